// File: doc/BRIEF.md
# EEPROM Page Write Sequencer

This block sits between the byte-level receiver of a two-wire serial memory slave and the memory array. The receiver announces the word address of a write transaction, then hands over each completed data byte. The sequencer keeps these bytes in a page latch that holds one page. It remembers which page slots were filled, and it places each byte at the next slot of the page. The slot index wraps within the page, so the transaction never leaves the page it started in.

When the receiver reports the end of the transaction, the sequencer decides whether to program. That end can be a regular stop, or a stop that cut a byte short. It programs only if at least one whole byte arrived and the write-protect input is low. In that case it raises `busy` for a fixed number of system clocks. During the first cycles of that window it issues one memory write for each filled slot, in ascending slot order. While `busy` is high, every request from the receiver is ignored. A transaction that carries only an address, with no data, sets nothing in motion.

Top module: `page_wr_seq`

## Requirements
- R1: After reset, `busy` and `mem_we` are low and the sequencer waits for an address.
- R2: After `addr_load` with address A, the k-th accepted byte (k counted from 0) goes to the location whose upper bits equal A[8:4] and whose low 4 bits equal (A[3:0] + k) mod 16.
- R3: Bytes beyond the 16th wrap to earlier slots of the same page, and the latest byte for a slot wins. The upper five address bits of every write equal those of the loaded address.
- R4: A `stop` that follows at least one accepted byte, with `wp` low, starts a program cycle. In that cycle each received slot is written once, carrying its latest data.
- R5: A `stop` after an address with no data bytes causes no write and leaves `busy` low.
- R6: A `stop_mid` pulse (a stop that arrives inside a byte) with no whole byte received causes no write. After one or more whole bytes, it writes those bytes exactly as R4 does.
- R7: If `wp` is high in the cycle where `stop` or `stop_mid` is sampled, no location is written and `busy` stays low.
- R8: `busy` rises in the cycle after the ending `stop` is sampled and stays high for exactly BUSY_CYCLES clocks.
- R9: While `busy` is high, `byte_valid`, `addr_load`, `stop` and `stop_mid` have no effect. A later stop without a fresh address starts nothing.
- R10: Bytes and stops that arrive before any address has been loaded are ignored.
- R11: `mem_we` is high only while `busy` is high. Within one program cycle the writes go to ascending slot indices, and the number of writes equals the number of distinct slots filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Word address of a write transaction is valid |
| start_addr | input | 9 | Word address including the half-select bit |
| byte_valid | input | 1 | One whole data byte has been received |
| byte_data | input | 8 | The received data byte |
| stop | input | 1 | Stop condition at a byte boundary |
| stop_mid | input | 1 | Stop condition that cut a byte short |
| wp | input | 1 | Write protect, sampled with the ending stop |
| busy | output | 1 | Program cycle in progress, bus requests refused |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 9 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
Random transactions use random start addresses and 0 to 20 bytes, with idle gaps between bytes. They also choose at random between a clean stop and a mid-byte stop, and sometimes raise protection. This shows whether slot placement and wrap are correct both near a page edge and at its start.

Directed cases cover the remaining boundaries. One starts at offset 14, and another sends 17 bytes, which separates in-page wrap from a spill into the next page. Others end with zero bytes, either by `stop` or by `stop_mid`, which separates a cancelled write from a committed one. Further cases send bytes with no address loaded, and inject requests during `busy` followed by an address-less probe. These reveal any request that leaked through.

// File: rtl/pws_pkg.sv
package pws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_PROG = 2'd2
    } pws_state_e;
endpackage

// File: rtl/pws_page_latch.sv
// Page latch: one data register and one filled flag per slot.
module pws_page_latch #(
    parameter  int ENTRIES = 16,
    parameter  int DATA_W  = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    output logic [ENTRIES-1:0] fill_mask
);
    logic [DATA_W-1:0] data_q [ENTRIES];
    logic [DATA_W-1:0] data_d [ENTRIES];
    logic [ENTRIES-1:0] mask_q, mask_d;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(e));

        always_comb begin
            data_d[e] = data_q[e];
            mask_d[e] = mask_q[e];
            if (clr) begin
                mask_d[e] = 1'b0;
            end else if (hit) begin
                data_d[e] = wr_data;
                mask_d[e] = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[e] <= '0;
                mask_q[e] <= 1'b0;
            end else begin
                data_q[e] <= data_d[e];
                mask_q[e] <= mask_d[e];
            end
        end
    end

    assign rd_data   = data_q[rd_idx];
    assign fill_mask = mask_q;
endmodule

// File: rtl/pws_busy_timer.sv
// Busy window counter: runs for CYCLES clocks after start.
module pws_busy_timer #(
    parameter  int CYCLES = 40,
    localparam int CNT_W  = $clog2(CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             run,
    output logic [CNT_W-1:0] count,
    output logic             last
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tim_t;

    tim_t tim_d, tim_q;

    assign last = tim_q.run && (tim_q.cnt == CNT_W'(CYCLES - 1));

    always_comb begin
        tim_d = tim_q;
        if (tim_q.run) begin
            if (last) begin
                tim_d.run = 1'b0;
                tim_d.cnt = '0;
            end else begin
                tim_d.cnt = tim_q.cnt + 1'b1;
            end
        end else if (start) begin
            tim_d.run = 1'b1;
            tim_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tim_q <= '0;
        else        tim_q <= tim_d;
    end

    assign run   = tim_q.run;
    assign count = tim_q.cnt;
endmodule

// File: rtl/page_wr_seq.sv
// Page write sequencer: collect bytes into a page latch, commit on stop.
module page_wr_seq #(
    parameter  int ADDR_W      = 9,
    parameter  int DATA_W      = 8,
    parameter  int PAGE_BYTES  = 16,
    parameter  int BUSY_CYCLES = 40,
    localparam int IDX_W       = $clog2(PAGE_BYTES),
    localparam int HI_W        = ADDR_W - IDX_W,
    localparam int CNT_W       = $clog2(BUSY_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop,
    input  logic              stop_mid,
    input  logic              wp,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    typedef struct packed {
        pws_pkg::pws_state_e st;
        logic [HI_W-1:0]     hi;
        logic [IDX_W-1:0]    ptr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  lat_clr, lat_wr, tim_start;
    logic                  tim_run, tim_last;
    logic [CNT_W-1:0]      tim_cnt;
    logic [PAGE_BYTES-1:0] mask;
    logic [DATA_W-1:0]     rd_data;
    logic                  end_req;

    assign end_req = stop || stop_mid;

    always_comb begin
        ctl_d     = ctl_q;
        lat_clr   = 1'b0;
        lat_wr    = 1'b0;
        tim_start = 1'b0;
        case (ctl_q.st)
            pws_pkg::ST_IDLE: begin
                if (addr_load) begin
                    ctl_d.hi  = start_addr[ADDR_W-1:IDX_W];
                    ctl_d.ptr = start_addr[IDX_W-1:0];
                    ctl_d.st  = pws_pkg::ST_FILL;
                    lat_clr   = 1'b1;
                end
            end
            pws_pkg::ST_FILL: begin
                if (end_req) begin
                    if ((|mask) && !wp) begin
                        ctl_d.st  = pws_pkg::ST_PROG;
                        tim_start = 1'b1;
                    end else begin
                        ctl_d.st = pws_pkg::ST_IDLE;
                        lat_clr  = 1'b1;
                    end
                end else if (addr_load) begin
                    ctl_d.hi  = start_addr[ADDR_W-1:IDX_W];
                    ctl_d.ptr = start_addr[IDX_W-1:0];
                    lat_clr   = 1'b1;
                end else if (byte_valid) begin
                    lat_wr    = 1'b1;
                    ctl_d.ptr = ctl_q.ptr + 1'b1;
                end
            end
            pws_pkg::ST_PROG: begin
                if (tim_last) begin
                    ctl_d.st = pws_pkg::ST_IDLE;
                    lat_clr  = 1'b1;
                end
            end
            default: ctl_d.st = pws_pkg::ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: pws_pkg::ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    pws_page_latch #(
        .ENTRIES (PAGE_BYTES),
        .DATA_W  (DATA_W)
    ) latch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (lat_clr),
        .wr_en     (lat_wr),
        .wr_idx    (ctl_q.ptr),
        .wr_data   (byte_data),
        .rd_idx    (tim_cnt[IDX_W-1:0]),
        .rd_data   (rd_data),
        .fill_mask (mask)
    );

    pws_busy_timer #(
        .CYCLES (BUSY_CYCLES)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tim_start),
        .run   (tim_run),
        .count (tim_cnt),
        .last  (tim_last)
    );

    // Slot index walks with the timer during the first PAGE_BYTES busy cycles.
    assign busy      = tim_run;
    assign mem_we    = (ctl_q.st == pws_pkg::ST_PROG) && tim_run
                       && (tim_cnt < CNT_W'(PAGE_BYTES))
                       && mask[tim_cnt[IDX_W-1:0]];
    assign mem_addr  = {ctl_q.hi, tim_cnt[IDX_W-1:0]};
    assign mem_wdata = rd_data;
endmodule

// File: rtl/pws_checker.sv
// Protocol checker, attached to every page_wr_seq instance.
module pws_checker #(
    parameter  int ADDR_W      = 9,
    parameter  int PAGE_BYTES  = 16,
    parameter  int BUSY_CYCLES = 40,
    localparam int IDX_W       = $clog2(PAGE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    // R8: busy window length measured by counter
    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == BUSY_CYCLES));

    // R11: writes only inside the busy window
    p_we_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R11: consecutive writes go to ascending slots
    p_slot_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
            (mem_addr[IDX_W-1:0] > $past(mem_addr[IDX_W-1:0])));

    // R3: one program cycle never leaves its page
    p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
            (mem_addr[ADDR_W-1:IDX_W] == $past(mem_addr[ADDR_W-1:IDX_W])));

    // R7: a program cycle never begins under protection
    p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp));
endmodule

bind page_wr_seq pws_checker #(
    .ADDR_W      (ADDR_W),
    .PAGE_BYTES  (PAGE_BYTES),
    .BUSY_CYCLES (BUSY_CYCLES)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp       (wp),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/page_wr_seq_tb_top.sv
module page_wr_seq_tb_top;
    localparam int BUSY = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0;
    logic [8:0] start_addr = '0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       stop = 1'b0;
    logic       stop_mid = 1'b0;
    logic       wp = 1'b0;
    logic       busy, mem_we;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    int wr_total = 0;
    logic [7:0] act_mem [512];
    logic [7:0] exp_mem [512];

    always #5 clk = ~clk;

    page_wr_seq #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop(stop),
        .stop_mid(stop_mid), .wp(wp), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // Array model fed by the write port, sampled mid-cycle.
    always @(negedge clk) begin
        if (mem_we) begin
            act_mem[mem_addr] = mem_wdata;
            wr_total = wr_total + 1;
        end
    end

    function automatic logic [8:0] slot_of(input logic [8:0] a, input int k);
        return {a[8:4], 4'(int'(a[3:0]) + k)};
    endfunction

    function automatic int distinct_slots(input int n);
        return (n > 16) ? 16 : n;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_mem(input string tag);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 512; i++)
            if (act_mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        n_tests++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s: location %0d actual %0h expected %0h (%0d differ)",
                     tag, first, act_mem[first], exp_mem[first], bad);
        end
    endtask

    // One write transaction, then observation of busy and the write port.
    task automatic txn(input string tag, input logic [8:0] a, input int n,
                       input bit mid, input bit wpv, input bit with_addr, input bit junk);
        logic [7:0] buf_d [32];
        int base_w;
        int seen;
        bit commit;
        if (with_addr) begin
            addr_load = 1'b1; start_addr = a;
            @(negedge clk);
            addr_load = 1'b0;
        end
        for (int k = 0; k < n; k++) begin
            buf_d[k] = 8'($urandom);
            byte_valid = 1'b1; byte_data = buf_d[k];
            @(negedge clk);
            byte_valid = 1'b0;
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
        wp = wpv;
        if (mid) stop_mid = 1'b1; else stop = 1'b1;
        base_w = wr_total;
        @(negedge clk);
        stop = 1'b0; stop_mid = 1'b0; wp = 1'b0;
        commit = with_addr && (n > 0) && !wpv;
        check({tag, " R8 busy start"}, int'(busy), int'(commit));
        seen = 0;
        while (busy && seen < BUSY + 5) begin
            seen++;
            if (junk) begin
                byte_valid = 1'($urandom); byte_data = 8'($urandom);
                addr_load = 1'($urandom); start_addr = 9'($urandom);
                stop = 1'($urandom); stop_mid = 1'($urandom);
            end
            @(negedge clk);
        end
        byte_valid = 1'b0; addr_load = 1'b0; stop = 1'b0; stop_mid = 1'b0;
        check({tag, " R8 busy length"}, seen, commit ? BUSY : 0);
        if (commit)
            for (int k = 0; k < n; k++) exp_mem[slot_of(a, k)] = buf_d[k];
        check({tag, " R11 write count"}, wr_total - base_w,
              commit ? distinct_slots(n) : 0);
        check_mem({tag, " R2 R4 contents"});
    endtask

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0421));
        for (int i = 0; i < 512; i++) begin
            act_mem[i] = '0;
            exp_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 mem_we after reset", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle busy", int'(busy), 0);

        txn("R2 page edge", 9'h1FE, 3, 1'b0, 1'b0, 1'b1, 1'b0);
        txn("R3 seventeen bytes", 9'h0A5, 17, 1'b0, 1'b0, 1'b1, 1'b0);
        txn("R3 twenty bytes", 9'h137, 20, 1'b0, 1'b0, 1'b1, 1'b0);
        txn("R5 dummy write", 9'h040, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        txn("R6 mid stop first byte", 9'h051, 0, 1'b1, 1'b0, 1'b1, 1'b0);
        txn("R6 mid stop later byte", 9'h0FC, 5, 1'b1, 1'b0, 1'b1, 1'b0);
        txn("R7 protected", 9'h010, 6, 1'b0, 1'b1, 1'b1, 1'b0);
        txn("R10 no address", 9'h000, 3, 1'b0, 1'b0, 1'b0, 1'b0);
        txn("R9 busy junk", 9'h188, 4, 1'b0, 1'b0, 1'b1, 1'b1);
        txn("R9 R10 probe after busy", 9'h000, 2, 1'b0, 1'b0, 1'b0, 1'b0);

        for (int t = 0; t < 30; t++) begin
            logic [8:0] a = 9'($urandom);
            int n = $urandom_range(0, 20);
            bit mid = 1'($urandom);
            bit wpv = ($urandom_range(0, 7) == 0);
            bit jk = 1'($urandom);
            txn("R4 random", a, n, mid, wpv, 1'b1, jk);
            if (jk) txn("R9 random probe", 9'h000, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule